// File: doc/BRIEF.md
# MII Management Interface Controller

This block lets software talk to an external Ethernet PHY over the two-wire management bus (MDC clock, bidirectional MDIO data). It presents four 32-bit registers on a simple synchronous write / combinational read port. To run a transaction, software loads the data word (for a write), then writes a command word naming the PHY, the register and the direction. After that it polls a busy flag. When busy drops after a read, the data register holds the 16-bit value returned by the PHY.

The controller derives MDC from the system clock through a programmable divisor. It produces the whole management frame with an output-enable and data pair, so a pad cell at chip level can build the open bus. The 32-bit all-ones preamble can be left out for PHYs that accept short frames. A self-clearing soft-reset bit returns the block to its power-up state and aborts any frame in flight.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset: busy reads 0, MDC is low, the MDIO output enable is low, the command and data registers read 0, and the control register reads (DEF_DIV-1) in its divisor field (bits starting at 9), with preamble suppression and soft reset at 0.
- R2: Command word layout: bit 15 requests a read, bit 14 requests a write, bits 9:5 give the PHY address and bits 4:0 give the register address. When both strobes are set, a read is performed. When neither is set, no frame is started and the command register keeps its old value.
- R3: A frame is sent with each bit MSB first, in this order: 32 ones (the preamble), start pattern 01, opcode (10 for read, 01 for write), 5-bit PHY address, 5-bit register address, turnaround, 16 data bits. For a write, the turnaround is driven as 1 then 0 and the data bits come from the data register.
- R4: In a read, MDIO is released (output enable low) from the first turnaround bit until the frame ends. MDIO input is sampled at each rising MDC edge of the 16 data bits, MSB first. When busy clears, the data register holds the result.
- R5: Status bit 0 (busy) reads 1 from the clock after an accepted command until the falling MDC edge that ends the last bit. While busy is 0, the output enable is low.
- R6: MDC period is (divisor field + 1) system clocks, and MDC is high for the lower half of the period. A field value of 0 is treated as a divisor of 2. MDC stays low while idle. The MDIO output and its enable change only while MDC is low.
- R7: With control bit 8 set, the preamble is omitted and a frame is 32 MDC cycles long, starting with the start pattern.
- R8: Writes to the command or data register while busy is 1 are ignored: no second frame is started, and both registers keep their values.
- R9: Writing 1 to control bit 0 aborts any frame and returns all registers to their reset values. That bit reads 1 for exactly one clock and then clears. During that clock, register writes are ignored.
- R10: Word offsets: command 0, data 1, status 2, control 3. All status bits other than bit 0 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Register read data (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The hardest case to reach from the ports is a soft reset or a new command arriving in the middle of a frame. The stimulus reaches it by starting a read, waiting a fixed number of clocks into the preamble, and then writing the control register. A second sequence issues a command and a data write while busy is high. After each of these, the bench counts MDC rising edges to show that no extra frame appeared, and reads the registers back. A bench-side PHY model drives the read data on falling MDC edges, so the sampling edge of the design is exercised directly.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_LEN   = 32;
    localparam int FRM_LEN   = 32;
    localparam int STREAM_W  = PRE_LEN + FRM_LEN;
    localparam int IDX_W     = $clog2(STREAM_W);
    localparam int WORD_W    = 16;
    localparam int ADR_W     = 5;
    localparam int TA_TOP    = WORD_W + 1;

    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] TA_DRIVE  = 2'b10;
    localparam logic [1:0] OP_WR     = 2'b01;
    localparam logic [1:0] OP_RD     = 2'b10;

    // command word fields (software-visible positions)
    localparam int CMD_RD_BIT  = 15;
    localparam int CMD_WR_BIT  = 14;
    localparam int CMD_PHY_LSB = 5;
    localparam int CMD_REG_LSB = 0;

    // control word fields
    localparam int CTL_RST_BIT   = 0;
    localparam int CTL_NOPRE_BIT = 8;
    localparam int CTL_DIV_LSB   = 9;

    // register word offsets
    localparam int OFS_CMD  = 0;
    localparam int OFS_DATA = 1;
    localparam int OFS_STAT = 2;
    localparam int OFS_CTRL = 3;

    typedef struct packed {
        logic                busy;
        logic                rd;
        logic [IDX_W-1:0]    idx;
        logic [STREAM_W-1:0] stream;
        logic [WORD_W-1:0]   shin;
    } eng_state_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_state_t;

    div_state_t       s_d, s_q;
    logic [DIV_W-1:0] top;
    logic [DIV_W:0]   period;
    logic [DIV_W-1:0] half;

    always_comb begin
        top    = (div_m1 == '0) ? DIV_W'(1) : div_m1;
        period = {1'b0, top} + 1'b1;
        half   = DIV_W'(period >> 1);
        s_d    = s_q;
        rise   = run && (s_q.cnt >= top);
        fall   = run && (s_q.cnt == half - 1'b1);
        if (!run) begin
            // park in the low phase so the first rise comes after a full low half
            s_d.cnt = half;
            s_d.mdc = 1'b0;
        end else begin
            s_d.cnt = rise ? '0 : s_q.cnt + 1'b1;
            s_d.mdc = (s_d.cnt < half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.mdc;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start,
    input  logic              rd_op,
    input  logic              no_pre,
    input  logic [ADR_W-1:0]  phy_adr,
    input  logic [ADR_W-1:0]  reg_adr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              mdc_rise,
    input  logic              mdc_fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_word,
    output logic              mdio_o,
    output logic              mdio_oe
);
    eng_state_t s_d, s_q;
    logic [1:0] op_bits;

    always_comb begin
        op_bits = rd_op ? OP_RD : OP_WR;
        s_d     = s_q;
        done    = 1'b0;
        if (clr) begin
            s_d = '0;
        end else if (!s_q.busy) begin
            if (start) begin
                s_d.busy   = 1'b1;
                s_d.rd     = rd_op;
                s_d.idx    = no_pre ? IDX_W'(FRM_LEN - 1) : IDX_W'(STREAM_W - 1);
                s_d.stream = {{PRE_LEN{1'b1}}, START_PAT, op_bits,
                              phy_adr, reg_adr, TA_DRIVE, wr_word};
                s_d.shin   = '0;
            end
        end else begin
            // sample on the rising MDC edge of every data bit of a read
            if (mdc_rise && s_q.rd && (s_q.idx < IDX_W'(WORD_W)))
                s_d.shin = {s_q.shin[WORD_W-2:0], mdio_i};
            // advance on the falling edge; the last fall ends the frame
            if (mdc_fall) begin
                if (s_q.idx == '0) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.idx = s_q.idx - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign rd_word = s_q.shin;
    assign mdio_oe = s_q.busy && !(s_q.rd && (s_q.idx <= IDX_W'(TA_TOP)));
    assign mdio_o  = mdio_oe && s_q.stream[s_q.idx];
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int BUS_W   = 32,
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int CTL_TOP = CTL_DIV_LSB + DIV_W;
    localparam int HI_USED = (CTL_TOP > WORD_W) ? CTL_TOP : WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] data;
        logic [DIV_W-1:0]  div_m1;
        logic              nopre;
        logic              rst;
    } regs_t;

    localparam regs_t REGS_RST = '{cmd: '0, data: '0,
                                   div_m1: DIV_W'(DEF_DIV - 1),
                                   nopre: 1'b0, rst: 1'b0};

    regs_t r_d, r_q;
    logic  wr_cmd, wr_data, wr_ctrl;
    logic  start, clr, busy, done, run;
    logic  rise, fall;
    logic  cmd_rd, cmd_wr;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] cmd_word;
    logic  soft_rst_flag;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata[BUS_W-1:HI_USED];

    always_comb begin
        wr_cmd  = reg_we && (reg_addr == ADDR_W'(OFS_CMD));
        wr_data = reg_we && (reg_addr == ADDR_W'(OFS_DATA));
        wr_ctrl = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
        cmd_rd  = reg_wdata[CMD_RD_BIT];
        cmd_wr  = reg_wdata[CMD_WR_BIT];
        r_d     = r_q;
        start   = 1'b0;
        clr     = 1'b0;
        if (r_q.rst) begin
            r_d.rst = 1'b0;
        end else begin
            if (done && r_q.cmd[CMD_RD_BIT])
                r_d.data = rd_word;
            if (wr_ctrl) begin
                if (reg_wdata[CTL_RST_BIT]) begin
                    r_d     = REGS_RST;
                    r_d.rst = 1'b1;
                    clr     = 1'b1;
                end else begin
                    r_d.div_m1 = reg_wdata[CTL_TOP-1:CTL_DIV_LSB];
                    r_d.nopre  = reg_wdata[CTL_NOPRE_BIT];
                end
            end else if (wr_cmd && !busy && (cmd_rd || cmd_wr)) begin
                r_d.cmd = reg_wdata[WORD_W-1:0];
                start   = 1'b1;
            end else if (wr_data && !busy) begin
                r_d.data = reg_wdata[WORD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign run = busy && !clr;

    mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_m1 (r_q.div_m1),
        .mdc    (mdc),
        .rise   (rise),
        .fall   (fall)
    );

    mdio_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .start    (start),
        .rd_op    (cmd_rd),
        .no_pre   (r_q.nopre),
        .phy_adr  (reg_wdata[CMD_PHY_LSB+ADR_W-1:CMD_PHY_LSB]),
        .reg_adr  (reg_wdata[CMD_REG_LSB+ADR_W-1:CMD_REG_LSB]),
        .wr_word  (r_q.data),
        .mdc_rise (rise),
        .mdc_fall (fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .rd_word  (rd_word),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    assign cmd_word      = r_q.cmd;
    assign soft_rst_flag = r_q.rst;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_CMD):  reg_rdata = BUS_W'(r_q.cmd);
            ADDR_W'(OFS_DATA): reg_rdata = BUS_W'(r_q.data);
            ADDR_W'(OFS_STAT): reg_rdata = BUS_W'(busy);
            ADDR_W'(OFS_CTRL): reg_rdata = (BUS_W'(r_q.div_m1) << CTL_DIV_LSB)
                                         | (BUS_W'(r_q.nopre) << CTL_NOPRE_BIT)
                                         | BUS_W'(r_q.rst);
            default:           reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
    parameter int ADDR_W = 2,
    parameter int BUS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BUS_W-1:0]  reg_wdata,
    input logic [15:0]       cmd_word,
    input logic              soft_rst_flag
);
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == '0 && !busy && !soft_rst_flag &&
         (reg_wdata[15] || reg_wdata[14])) |=> busy);

    assert_idle_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    assert_idle_mdc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_mdio_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == '0) |=> $stable(cmd_word));

    assert_rst_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_flag |=> (!soft_rst_flag && !busy));
endmodule

bind mdio_mgmt mdio_mgmt_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mdc           (mdc),
    .mdio_o        (mdio_o),
    .mdio_oe       (mdio_oe),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .cmd_word      (cmd_word),
    .soft_rst_flag (soft_rst_flag)
);

// File: tb/tb_mdio_mgmt.sv
module tb_mdio_mgmt;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        int          n;
        logic [63:0] bits;
        logic [63:0] oe;
        bit          rd;
        logic [15:0] resp;
    } exp_t;

    exp_t exp_q[$];

    int  mdc_rises = 0;
    time last_rise = 0;
    time mdc_per = 0;
    time mdc_hi = 0;

    mdio_mgmt dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge mdc) begin
        mdc_rises++;
        mdc_per   = $time - last_rise;
        last_rise = $time;
    end
    always @(negedge mdc) mdc_hi = $time - last_rise;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            reg_rd(2'd2, s);
            if (s[0] == 1'b0) begin
                repeat (2) @(negedge clk);
                return;
            end
        end
        check(1'b0, "R5 busy never cleared", 1, 0);
    endtask

    function automatic exp_t mk(bit rd, bit [4:0] phy, bit [4:0] ra, bit [15:0] wd,
                                bit nopre, bit [15:0] resp);
        exp_t e;
        e.n    = nopre ? 32 : 64;
        e.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, wd};
        e.oe   = '1;
        if (rd) e.oe[17:0] = '0;
        e.rd   = rd;
        e.resp = resp;
        return e;
    endfunction

    // monitor: PHY model and frame comparison
    initial begin
        forever begin
            exp_t e;
            int mism;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            mism = 0;
            for (int i = e.n - 1; i >= 0; i--) begin
                @(posedge mdc);
                #1;
                if (mdio_oe !== e.oe[i] || (e.oe[i] && mdio_o !== e.bits[i])) mism++;
                @(negedge mdc);
                #1;
                if (e.rd && i >= 1 && i - 1 < 16) mdio_i = e.resp[i-1];
                else mdio_i = 1'b1;
            end
            check(mism == 0, "R3/R4/R7 frame bits or enable mismatch", mism, 0);
        end
    end

    task automatic run_cmd(input bit rd, input bit [4:0] phy, input bit [4:0] ra,
                           input bit [15:0] wd, input bit nopre, input bit [15:0] resp,
                           input logic [31:0] cmdword);
        exp_q.push_back(mk(rd, phy, ra, wd, nopre, resp));
        reg_wr(2'd0, cmdword);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(2'd2, v); check(v == 32'd0, "R1 status after reset", v, 0);
        reg_rd(2'd1, v); check(v == 32'd0, "R1 data after reset", v, 0);
        reg_rd(2'd0, v); check(v == 32'd0, "R1 command after reset", v, 0);
        reg_rd(2'd3, v); check(v == (32'd39 << 9), "R1 control after reset", v, 32'd39 << 9);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {mdc, mdio_oe}, 0);

        // R10 control readback at offset 3, divisor 4
        reg_wr(2'd3, 32'd3 << 9);
        reg_rd(2'd3, v); check(v == (32'd3 << 9), "R10 control readback", v, 32'd3 << 9);

        // write frame with preamble
        reg_wr(2'd1, 32'h0000_A5C3);
        run_cmd(1'b0, 5'h11, 5'h0A, 16'hA5C3, 1'b0, 16'h0, (32'h1 << 14) | (32'h11 << 5) | 32'h0A);
        reg_rd(2'd2, v); check(v == 32'd1, "R5 R10 busy set after command", v, 1);
        wait_idle();
        check(mdc_per == 4 * CLK_PERIOD, "R6 MDC period div4", mdc_per, 4 * CLK_PERIOD);
        check(mdc_hi == 2 * CLK_PERIOD, "R6 MDC high time div4", mdc_hi, 2 * CLK_PERIOD);
        reg_rd(2'd0, v); check(v == 32'h0000_422A, "R2 command readback", v, 32'h422A);

        // read frame with preamble
        run_cmd(1'b1, 5'h03, 5'h01, 16'hA5C3, 1'b0, 16'h1234, (32'h1 << 15) | (32'h03 << 5) | 32'h01);
        wait_idle();
        reg_rd(2'd1, v); check(v == 32'h1234, "R4 read result", v, 32'h1234);

        // preamble suppressed, divisor 5
        reg_wr(2'd3, (32'd4 << 9) | (32'd1 << 8));
        reg_wr(2'd1, 32'h0000_5A0F);
        r0 = mdc_rises;
        run_cmd(1'b0, 5'h1F, 5'h10, 16'h5A0F, 1'b1, 16'h0, (32'h1 << 14) | (32'h1F << 5) | 32'h10);
        wait_idle();
        check(mdc_rises - r0 == 32, "R7 short frame length", mdc_rises - r0, 32);
        check(mdc_per == 5 * CLK_PERIOD, "R6 MDC period div5", mdc_per, 5 * CLK_PERIOD);
        check(mdc_hi == 2 * CLK_PERIOD, "R6 MDC high time div5", mdc_hi, 2 * CLK_PERIOD);

        run_cmd(1'b1, 5'h00, 5'h1F, 16'h5A0F, 1'b1, 16'hBEEF, (32'h1 << 15) | 32'h1F);
        wait_idle();
        reg_rd(2'd1, v); check(v == 32'hBEEF, "R4 R7 short read result", v, 32'hBEEF);

        // both strobes: read wins
        run_cmd(1'b1, 5'h05, 5'h02, 16'hBEEF, 1'b1, 16'h0F0F, (32'h3 << 14) | (32'h05 << 5) | 32'h02);
        wait_idle();
        reg_rd(2'd1, v); check(v == 32'h0F0F, "R2 both strobes perform read", v, 32'h0F0F);

        // no strobe: nothing happens
        r0 = mdc_rises;
        reg_wr(2'd0, 32'h0000_0021);
        reg_rd(2'd2, v); check(v == 32'd0, "R2 no strobe stays idle", v, 0);
        repeat (20) @(negedge clk);
        check(mdc_rises == r0, "R2 no strobe no MDC", mdc_rises - r0, 0);
        reg_rd(2'd0, v); check(v == 32'h0000_C0A2, "R2 no strobe keeps command", v, 32'hC0A2);

        // writes while busy ignored
        reg_wr(2'd1, 32'h0000_1111);
        r0 = mdc_rises;
        run_cmd(1'b0, 5'h02, 5'h04, 16'h1111, 1'b1, 16'h0, (32'h1 << 14) | (32'h02 << 5) | 32'h04);
        repeat (10) @(negedge clk);
        reg_wr(2'd0, (32'h1 << 15) | 32'h7);
        reg_wr(2'd1, 32'h0000_2222);
        wait_idle();
        repeat (20) @(negedge clk);
        check(mdc_rises - r0 == 32, "R8 single frame only", mdc_rises - r0, 32);
        reg_rd(2'd0, v); check(v == 32'h0000_4044, "R8 command unchanged", v, 32'h4044);
        reg_rd(2'd1, v); check(v == 32'h1111, "R8 data unchanged", v, 32'h1111);

        // divisor field 0 behaves as 2
        reg_wr(2'd3, 32'd1 << 8);
        run_cmd(1'b0, 5'h08, 5'h08, 16'h1111, 1'b1, 16'h0, (32'h1 << 14) | (32'h08 << 5) | 32'h08);
        wait_idle();
        check(mdc_per == 2 * CLK_PERIOD, "R6 field 0 period", mdc_per, 2 * CLK_PERIOD);
        check(mdc_hi == 1 * CLK_PERIOD, "R6 field 0 high time", mdc_hi, CLK_PERIOD);

        // soft reset mid-frame (not scored by the monitor)
        reg_wr(2'd3, 32'd3 << 9);
        reg_wr(2'd0, (32'h1 << 15) | 32'h3);
        repeat (20) @(negedge clk);
        reg_wr(2'd3, 32'h1);
        reg_rd(2'd3, v); check(v == ((32'd39 << 9) | 32'd1), "R9 reset bit visible one clock", v, (32'd39 << 9) | 1);
        reg_rd(2'd2, v); check(v == 32'd0, "R9 busy aborted", v, 0);
        check(mdio_oe == 1'b0 && mdc == 1'b0, "R9 pins idle after abort", {mdc, mdio_oe}, 0);
        @(negedge clk);
        reg_rd(2'd3, v); check(v == (32'd39 << 9), "R9 reset bit self-clears", v, 32'd39 << 9);
        reg_rd(2'd0, v); check(v == 32'd0, "R9 command cleared", v, 0);
        reg_rd(2'd1, v); check(v == 32'd0, "R9 data cleared", v, 0);
        r0 = mdc_rises;
        repeat (100) @(negedge clk);
        check(mdc_rises == r0, "R9 no MDC after abort", mdc_rises - r0, 0);
        check(exp_q.size() == 0, "R3 all frames observed", exp_q.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule